// File: doc/BRIEF.md
# Prioritized Peripheral Pin Multiplexer

This block controls eight shared bidirectional pads. Each pad can be used as general-purpose I/O or taken over by one of several peripheral functions: a chip-select output, a four-wire SPI pin set, and two asynchronous serial channels. For every pad the block decides which function owns it by fixed priority. Chip select comes first, then the SPI or serial functions, and general-purpose I/O comes last. From that owner it produces the pad output value and the output enable.

A small register bus gives access to two registers. The output-value register sits at word offset 0 and the direction register at word offset 1. Pad levels pass through a synchronizer. After that they are either read back on the bus or routed to the input of the peripheral that owns the pad. A peripheral input whose pad is not owned by a receiving function sees a constant high.

Top module: `prio_pin_mux`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every pad output enable is 0. Both registers are 0 and read data is 0. Every peripheral input is 1.
- R2: A pad owned by no peripheral has its output enable equal to its direction-register bit and its output equal to its value-register bit. Both take effect one cycle after the register or control input changes.
- R3: When the chip-select enable is 1, pad 7 is an output that drives the chip-select level. This holds whatever the SPI state is.
- R4: With SPI enabled, pads 7, 6, 5 and 4 are slave-select, clock, MOSI and MISO. In master mode (spi_master=1) pads 7..5 are outputs and pad 4 is an input. In slave mode the directions are reversed. An SPI pad acting as an input drives output value 0.
- R5: Serial channel 0 transmit enable makes pad 1 an output carrying its transmit data. Its receive enable makes pad 0 an input. Both override the direction register.
- R6: Serial channel 1 owns pad 3 (transmit, output) and pad 2 (receive, input) only when its enable is 1 and the remap input is 1. Otherwise those pads stay general-purpose.
- R7: A read at offset 0 returns, for each bit, the value-register bit where the direction bit is 1 and the synchronized pad level where the direction bit is 0.
- R8: The direction register reads back at offset 1. Writes to any offset other than 0 and 1 change neither register. Reads of those offsets return 0.
- R9: A pad level change reaches read data on the third rising clock edge after it is applied: two synchronizer stages plus the read-data register.
- R10: A peripheral input carries the synchronized pad level only when its function owns the pad as an input. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| cs_en | input | 1 | Chip-select function enable |
| cs_level | input | 1 | Chip-select output level |
| spi_en | input | 1 | SPI function enable |
| spi_master | input | 1 | 1 = SPI master directions, 0 = slave |
| spi_ss_o | input | 1 | SPI slave-select output value |
| spi_sck_o | input | 1 | SPI clock output value |
| spi_mosi_o | input | 1 | SPI MOSI output value |
| spi_miso_o | input | 1 | SPI MISO output value |
| spi_ss_i | output | 1 | Slave-select to SPI |
| spi_sck_i | output | 1 | Clock to SPI |
| spi_mosi_i | output | 1 | MOSI to SPI |
| spi_miso_i | output | 1 | MISO to SPI |
| ser0_tx_en | input | 1 | Serial channel 0 transmit enable |
| ser0_rx_en | input | 1 | Serial channel 0 receive enable |
| ser0_txd | input | 1 | Serial channel 0 transmit data |
| ser0_rxd | output | 1 | Serial channel 0 receive data |
| ser1_tx_en | input | 1 | Serial channel 1 transmit enable |
| ser1_rx_en | input | 1 | Serial channel 1 receive enable |
| ser1_remap | input | 1 | Allows serial channel 1 onto pads 3..2 |
| ser1_txd | input | 1 | Serial channel 1 transmit data |
| ser1_rxd | output | 1 | Serial channel 1 receive data |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values (registered) |
| pad_oe | output | 8 | Pad output enables (registered) |

## Verification
A wrong ownership decision shows up on pad_oe and pad_out one clock after the control inputs settle. A pad can then drive against an external source, or stay silent where it should drive. A corrupted value or direction register shows up on the same pads, and on the offset-0 read, within one registered read. A fault in the synchronizer or in input routing shows up on read data or on a peripheral input three edges after the pad changes. The clearest symptom there is a peripheral input that should sit high but instead follows a pad it does not own.

// File: rtl/pm_pkg.sv
package pm_pkg;

  localparam int unsigned PINS = 8;

  // fixed pin map: each peripheral decodes its own bit position
  localparam int unsigned PIN_CS   = 7;
  localparam int unsigned PIN_SS   = 7;
  localparam int unsigned PIN_SCK  = 6;
  localparam int unsigned PIN_MOSI = 5;
  localparam int unsigned PIN_MISO = 4;
  localparam int unsigned PIN_S1TX = 3;
  localparam int unsigned PIN_S1RX = 2;
  localparam int unsigned PIN_S0TX = 1;
  localparam int unsigned PIN_S0RX = 0;

  typedef enum logic [2:0] {
    OWN_GPIO = 3'd0,
    OWN_CS   = 3'd1,
    OWN_SPI  = 3'd2,
    OWN_SER0 = 3'd3,
    OWN_SER1 = 3'd4
  } owner_e;

  typedef struct packed {
    logic cs_en;
    logic cs_level;
    logic spi_en;
    logic spi_master;
    logic ss_o;
    logic sck_o;
    logic mosi_o;
    logic miso_o;
    logic s0_tx_en;
    logic s0_rx_en;
    logic s0_txd;
    logic s1_tx_en;
    logic s1_rx_en;
    logic s1_txd;
    logic remap;
  } ctl_t;

  typedef struct packed {
    owner_e owner;
    logic   drive;
    logic   level;
  } pin_res_t;

  // priority: chip select > SPI / serial > general-purpose
  function automatic pin_res_t resolve_pin(input int unsigned idx, input ctl_t c,
                                           input logic gp_dir, input logic gp_val);
    pin_res_t r;
    r.owner = OWN_GPIO;
    r.drive = gp_dir;
    r.level = gp_val;
    if (idx == PIN_CS && c.cs_en) begin
      r.owner = OWN_CS;
      r.drive = 1'b1;
      r.level = c.cs_level;
    end else if (c.spi_en && idx == PIN_SS) begin
      r.owner = OWN_SPI;
      r.drive = c.spi_master;
      r.level = c.spi_master & c.ss_o;
    end else if (c.spi_en && idx == PIN_SCK) begin
      r.owner = OWN_SPI;
      r.drive = c.spi_master;
      r.level = c.spi_master & c.sck_o;
    end else if (c.spi_en && idx == PIN_MOSI) begin
      r.owner = OWN_SPI;
      r.drive = c.spi_master;
      r.level = c.spi_master & c.mosi_o;
    end else if (c.spi_en && idx == PIN_MISO) begin
      r.owner = OWN_SPI;
      r.drive = ~c.spi_master;
      r.level = ~c.spi_master & c.miso_o;
    end else if (c.remap && c.s1_tx_en && idx == PIN_S1TX) begin
      r.owner = OWN_SER1;
      r.drive = 1'b1;
      r.level = c.s1_txd;
    end else if (c.remap && c.s1_rx_en && idx == PIN_S1RX) begin
      r.owner = OWN_SER1;
      r.drive = 1'b0;
      r.level = 1'b0;
    end else if (c.s0_tx_en && idx == PIN_S0TX) begin
      r.owner = OWN_SER0;
      r.drive = 1'b1;
      r.level = c.s0_txd;
    end else if (c.s0_rx_en && idx == PIN_S0RX) begin
      r.owner = OWN_SER0;
      r.drive = 1'b0;
      r.level = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pm_regs.sv
module pm_regs #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned OFS_DATA = 0,
  parameter int unsigned OFS_DIR  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  synced,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  rdata
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);

  logic hit_data, hit_dir;
  logic [WIDTH-1:0] rd_next;

  assign hit_data = (addr == A_DATA);
  assign hit_dir  = (addr == A_DIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (we) begin
      if (hit_data) data_q <= wdata;
      if (hit_dir)  dir_q  <= wdata;
    end
  end

  // per-bit readback source follows the direction register
  always_comb begin
    rd_next = '0;
    if (hit_data)     rd_next = (data_q & dir_q) | (synced & ~dir_q);
    else if (hit_dir) rd_next = dir_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  a_r1_regs_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (data_q == '0 && dir_q == '0 && rdata == '0));

  a_r8_undef_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (we && !hit_data && !hit_dir) |=> (data_q == $past(data_q) && dir_q == $past(dir_q)));

  a_r8_undef_read_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hit_data) && !$past(hit_dir)) |-> rdata == '0);

endmodule

// File: rtl/pm_resolve.sv
module pm_resolve
  import pm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  ctl_t            ctl,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] data_q,
  input  logic [PINS-1:0] synced,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            ss_i,
  output logic            sck_i,
  output logic            mosi_i,
  output logic            miso_i,
  output logic            s0_rxd,
  output logic            s1_rxd
);

  owner_e          own [PINS];
  logic [PINS-1:0] drv;
  logic [PINS-1:0] lvl;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_res_t res;
    assign res    = resolve_pin(i, ctl, dir_q[i], data_q[i]);
    assign own[i] = res.owner;
    assign drv[i] = res.drive;
    assign lvl[i] = res.level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= drv;
      pad_out <= lvl;
    end
  end

  // receive routing: only an input-owning function sees the pad, else idle high
  logic spi_slave_in, spi_master_in;
  assign spi_slave_in  = ~ctl.spi_master;
  assign spi_master_in = ctl.spi_master;

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_i   <= 1'b1;
      sck_i  <= 1'b1;
      mosi_i <= 1'b1;
      miso_i <= 1'b1;
      s0_rxd <= 1'b1;
      s1_rxd <= 1'b1;
    end else begin
      ss_i   <= (own[PIN_SS]   == OWN_SPI  && spi_slave_in)  ? synced[PIN_SS]   : 1'b1;
      sck_i  <= (own[PIN_SCK]  == OWN_SPI  && spi_slave_in)  ? synced[PIN_SCK]  : 1'b1;
      mosi_i <= (own[PIN_MOSI] == OWN_SPI  && spi_slave_in)  ? synced[PIN_MOSI] : 1'b1;
      miso_i <= (own[PIN_MISO] == OWN_SPI  && spi_master_in) ? synced[PIN_MISO] : 1'b1;
      s0_rxd <= (own[PIN_S0RX] == OWN_SER0) ? synced[PIN_S0RX] : 1'b1;
      s1_rxd <= (own[PIN_S1RX] == OWN_SER1) ? synced[PIN_S1RX] : 1'b1;
    end
  end

  a_r1_reset_hiz: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && ss_i && s0_rxd && s1_rxd));

  a_r3_cs_owns_pin: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl.cs_en) && !$past(rst)) |-> (pad_oe[PIN_CS] && pad_out[PIN_CS] == $past(ctl.cs_level)));

  a_r4_spi_dirs: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl.spi_en) && !$past(rst)) |->
      (pad_oe[PIN_MISO] == !$past(ctl.spi_master) && pad_oe[PIN_SCK] == $past(ctl.spi_master)));

  a_r5_rx0_input: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl.s0_rx_en) && !$past(rst)) |-> !pad_oe[PIN_S0RX]);

  a_r6_remap_gate: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctl.remap) && !$past(rst)) |->
      (pad_oe[3:2] == $past(dir_q[3:2]) && pad_out[3:2] == $past(data_q[3:2])));

  a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctl.s0_rx_en) && !$past(ctl.spi_en)) |-> (s0_rxd && ss_i && miso_i));

endmodule

// File: rtl/prio_pin_mux.sv
module prio_pin_mux
  import pm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OFS_DATA    = 0,
  parameter int unsigned OFS_DIR     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cs_en,
  input  logic              cs_level,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic              spi_ss_o,
  input  logic              spi_sck_o,
  input  logic              spi_mosi_o,
  input  logic              spi_miso_o,
  output logic              spi_ss_i,
  output logic              spi_sck_i,
  output logic              spi_mosi_i,
  output logic              spi_miso_i,
  input  logic              ser0_tx_en,
  input  logic              ser0_rx_en,
  input  logic              ser0_txd,
  output logic              ser0_rxd,
  input  logic              ser1_tx_en,
  input  logic              ser1_rx_en,
  input  logic              ser1_remap,
  input  logic              ser1_txd,
  output logic              ser1_rxd,
  input  logic [7:0]        pad_in,
  output logic [7:0]        pad_out,
  output logic [7:0]        pad_oe
);

  ctl_t            ctl;
  logic [PINS-1:0] synced;
  logic [PINS-1:0] data_q;
  logic [PINS-1:0] dir_q;

  assign ctl.cs_en      = cs_en;
  assign ctl.cs_level   = cs_level;
  assign ctl.spi_en     = spi_en;
  assign ctl.spi_master = spi_master;
  assign ctl.ss_o       = spi_ss_o;
  assign ctl.sck_o      = spi_sck_o;
  assign ctl.mosi_o     = spi_mosi_o;
  assign ctl.miso_o     = spi_miso_o;
  assign ctl.s0_tx_en   = ser0_tx_en;
  assign ctl.s0_rx_en   = ser0_rx_en;
  assign ctl.s0_txd     = ser0_txd;
  assign ctl.s1_tx_en   = ser1_tx_en;
  assign ctl.s1_rx_en   = ser1_rx_en;
  assign ctl.s1_txd     = ser1_txd;
  assign ctl.remap      = ser1_remap;

  pm_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (synced)
  );

  pm_regs #(.ADDR_W(ADDR_W), .WIDTH(PINS), .OFS_DATA(OFS_DATA), .OFS_DIR(OFS_DIR)) i_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .synced (synced),
    .data_q (data_q),
    .dir_q  (dir_q),
    .rdata  (reg_rdata)
  );

  pm_resolve i_resolve (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .dir_q   (dir_q),
    .data_q  (data_q),
    .synced  (synced),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .ss_i    (spi_ss_i),
    .sck_i   (spi_sck_i),
    .mosi_i  (spi_mosi_i),
    .miso_i  (spi_miso_i),
    .s0_rxd  (ser0_rxd),
    .s1_rxd  (ser1_rxd)
  );

  // R2: a pad nobody claims follows the registers
  a_r2_gpio_follow: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cs_en) && !$past(spi_en) && !$past(ser0_tx_en) && !$past(ser0_rx_en))
      |-> (pad_oe[7:4] == $past(dir_q[7:4]) && pad_oe[1:0] == $past(dir_q[1:0])));

endmodule

// File: tb/test_prio_pin_mux.sv
module test_prio_pin_mux;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic cs_en = 0, cs_level = 0, spi_en = 0, spi_master = 0;
  logic spi_ss_o = 1'b0, spi_sck_o = 1'b1, spi_mosi_o = 1'b1, spi_miso_o = 1'b0;
  logic spi_ss_i, spi_sck_i, spi_mosi_i, spi_miso_i;
  logic ser0_tx_en = 0, ser0_rx_en = 0, ser0_txd = 1'b1, ser0_rxd;
  logic ser1_tx_en = 0, ser1_rx_en = 0, ser1_remap = 0, ser1_txd = 1'b0, ser1_rxd;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_pin_mux i_prio_pin_mux (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cs_en(cs_en), .cs_level(cs_level), .spi_en(spi_en),
    .spi_master(spi_master), .spi_ss_o(spi_ss_o), .spi_sck_o(spi_sck_o),
    .spi_mosi_o(spi_mosi_o), .spi_miso_o(spi_miso_o), .spi_ss_i(spi_ss_i),
    .spi_sck_i(spi_sck_i), .spi_mosi_i(spi_mosi_i), .spi_miso_i(spi_miso_i),
    .ser0_tx_en(ser0_tx_en), .ser0_rx_en(ser0_rx_en), .ser0_txd(ser0_txd),
    .ser0_rxd(ser0_rxd), .ser1_tx_en(ser1_tx_en), .ser1_rx_en(ser1_rx_en),
    .ser1_remap(ser1_remap), .ser1_txd(ser1_txd), .ser1_rxd(ser1_rxd),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {cs_en, cs_level, spi_en, spi_master, s0tx, s0rx, s1tx, s1rx, remap, dir, data, exp_oe, exp_out}
  localparam logic [40:0] VEC [12] = '{
    {9'b0_0_0_0_0_0_0_0_0, 8'hA5, 8'hC3, 8'hA5, 8'hC3},  // R2 all general-purpose
    {9'b1_0_0_0_0_0_0_0_0, 8'hA5, 8'hC3, 8'hA5, 8'h43},  // R3 chip select low
    {9'b0_0_1_1_0_0_0_0_0, 8'hA5, 8'hC3, 8'hE5, 8'h63},  // R4 SPI master
    {9'b0_0_1_0_0_0_0_0_0, 8'hA5, 8'hC3, 8'h15, 8'h03},  // R4 SPI slave
    {9'b1_1_1_1_0_0_0_0_0, 8'hA5, 8'hC3, 8'hE5, 8'hE3},  // R3 chip select over SPI
    {9'b0_0_0_0_1_1_0_0_0, 8'hA5, 8'hC3, 8'hA6, 8'hC2},  // R5 channel 0 both
    {9'b0_0_0_0_0_0_1_1_0, 8'hA5, 8'hC3, 8'hA5, 8'hC3},  // R6 channel 1 without remap
    {9'b0_0_0_0_0_0_1_1_1, 8'hA5, 8'hC3, 8'hA9, 8'hC3},  // R6 channel 1 remapped
    {9'b1_0_1_0_1_1_1_1_1, 8'hA5, 8'hC3, 8'h9A, 8'h02},  // R3 R4 R5 R6 all together
    {9'b0_0_0_0_0_1_0_0_0, 8'hA5, 8'hC3, 8'hA4, 8'hC2},  // R5 receive only
    {9'b0_0_0_0_0_0_0_0_1, 8'hA5, 8'hC3, 8'hA5, 8'hC3},  // R6 remap without enables
    {9'b0_0_1_1_0_0_0_0_0, 8'hFF, 8'h5A, 8'hEF, 8'h6A}   // R4 master, all directions out
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [8:0] c);
    {cs_en, cs_level, spi_en, spi_master, ser0_tx_en, ser0_rx_en,
     ser1_tx_en, ser1_rx_en, ser1_remap} = c;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 peripheral inputs", {2'b0, spi_ss_i, spi_sck_i, spi_mosi_i, spi_miso_i, ser0_rxd, ser1_rxd}, 8'h3F);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pad_oe after release", pad_oe, 8'h00);
    bus_read(3'd1, rv);
    check("R1 dir cleared", rv, 8'h00);

    // table walk: R2..R6
    foreach (VEC[n]) begin
      set_ctl(VEC[n][40:32]);
      bus_write(3'd1, VEC[n][31:24]);
      bus_write(3'd0, VEC[n][23:16]);
      @(negedge clk);
      check($sformatf("R2-table oe vec%0d", n), pad_oe, VEC[n][15:8]);
      check($sformatf("R2-table out vec%0d", n), pad_out, VEC[n][7:0]);
    end

    // R7: direction-selected readback
    set_ctl(9'b0);
    bus_write(3'd1, 8'hF0);
    bus_write(3'd0, 8'h3C);
    pad_in = 8'h96;
    repeat (4) @(negedge clk);
    bus_read(3'd0, rv);
    check("R7 mixed readback", rv, 8'h36);

    // R8: direction readback, undefined offset
    bus_read(3'd1, rv);
    check("R8 dir readback", rv, 8'hF0);
    bus_write(3'd5, 8'hFF);
    bus_read(3'd5, rv);
    check("R8 undefined read zero", rv, 8'h00);
    bus_read(3'd1, rv);
    check("R8 dir untouched", rv, 8'hF0);
    bus_read(3'd0, rv);
    check("R8 data untouched", rv, 8'h36);

    // R9: synchronizer latency, reading offset 0 with low nibble inputs
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    pad_in = 8'h0F;
    @(negedge clk);
    @(negedge clk);
    check("R9 still old after 2 edges", reg_rdata, 8'h30);
    @(negedge clk);
    check("R9 new after 3 edges", reg_rdata, 8'h3F);

    // R10: peripheral input routing
    set_ctl(9'b0_0_1_0_0_0_0_0_0);  // SPI slave
    pad_in = 8'b0101_0000;
    repeat (4) @(negedge clk);
    check("R10 slave inputs", {2'b0, spi_ss_i, spi_sck_i, spi_mosi_i, spi_miso_i, ser0_rxd, ser1_rxd}, 8'b0001_0111);
    set_ctl(9'b1_0_1_0_0_1_0_1_1);  // chip select takes pad 7, both receivers on
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    check("R10 cs blocks ss, receivers follow", {2'b0, spi_ss_i, spi_sck_i, spi_mosi_i, spi_miso_i, ser0_rxd, ser1_rxd}, 8'b0010_0100);
    set_ctl(9'b0_0_1_1_0_0_0_0_0);  // SPI master
    repeat (4) @(negedge clk);
    check("R10 master miso follows pad", {7'b0, spi_miso_i}, 8'h00);
    check("R10 master ss idle high", {7'b0, spi_ss_i}, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule